// File: doc/BRIEF.md
# Per-CPU Interrupt Mailbox with Busy Lock

This block takes interrupt messages from an external bus and files each one in a slot that belongs to the target CPU. There are up to 32 slots. Each slot holds a busy flag, a 5-bit source id and two 64-bit data words. A message for a free slot is accepted in the same cycle. The slot then locks and a post of the shared external vector goes to that CPU. A message for a locked slot is turned away, so the sender has to try again later.

Software reaches the slots through a register port that carries the id of the requesting CPU. Data words and status can be read by explicit slot index. They can also be read through self-addressed offsets, which select the slot of the requester. A write to a status register, by index or self-addressed, loads the busy flag from bit 5. Writing 0 frees the slot for the next message.

Top module: `irq_mailbox`

## Requirements
- R1: After reset every slot is free with zero source id and zero data words, so every mapped read returns 0 and post_valid is low.
- R2: A message whose target slot is free raises msg_accept in the cycle msg_valid is high. At the next edge the slot becomes busy and stores the source id and both data words.
- R3: A message whose target slot is busy raises msg_reject (never msg_accept), and the slot's busy flag, source id and data words are left unchanged.
- R4: In the cycle after an accept, post_valid is 1, post_cpu is the target CPU and post_vec is the value ext_vec had in the accepting cycle. post_valid is 0 after any cycle with no accept.
- R5: A read of offset 0x400 + 8n returns the first data word of slot n, and a read of 0x500 + 8n returns its second. reg_rdata carries the value in the cycle after the read.
- R6: Reads of offsets 0x600 and 0x700 return the first and second data word of the slot selected by reg_req_id.
- R7: A read of offset 0x900 + 8n returns slot n's busy flag in bit 5 and its source id in bits 4:0, with bits 63:6 at zero.
- R8: A read of offset 0xB00 returns the status of the slot selected by reg_req_id, in the same layout as R7.
- R9: A write to 0x900 + 8n, or to 0xB00 with reg_req_id = n, sets slot n's busy flag to bit 5 of reg_wdata. The source id and data words of that slot are not changed.
- R10: When a status write clears a busy slot in the same cycle that a message for that slot arrives, the message is rejected, and the slot ends up free with its old contents.
- R11: When a message for a free slot and a status write to the same slot fall in one cycle, the message is accepted and the slot ends up busy with the new contents.
- R12: Reads of unmapped or misaligned offsets return 0. Writes to data-word offsets have no effect on the slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | 1 | Incoming message present |
| msg_cpu | input | 5 | Target CPU of the message |
| msg_src | input | 5 | Source id carried by the message |
| msg_d0 | input | 64 | First data word of the message |
| msg_d1 | input | 64 | Second data word of the message |
| ext_vec | input | 6 | Shared vector posted on accept |
| msg_accept | output | 1 | Message taken this cycle |
| msg_reject | output | 1 | Message refused this cycle, sender retries |
| reg_en | input | 1 | Register access this cycle |
| reg_we | input | 1 | 1 for write, 0 for read |
| reg_addr | input | 12 | Register offset |
| reg_req_id | input | 5 | Id of the CPU making the access |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, valid the cycle after a read |
| post_valid | output | 1 | Interrupt post to a CPU |
| post_cpu | output | 5 | CPU receiving the post |
| post_vec | output | 6 | Vector being posted |

## Verification
Two things can land on one slot in the same cycle: a message arriving and software rewriting that slot's busy flag. The bench provokes this on purpose. It drives a busy-clearing write together with a message to the locked slot, and it drives a write together with a message to a free slot. It also repeats such collisions at random over a small set of CPUs. A behavioural model in the bench judges every cycle: it decides accept from the busy flag before the edge, applies the software write, and then lets an accept override it. Follow-up reads of the status must match that order.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int CPU_W    = 5;
  localparam int SRC_W    = 5;
  localparam int ADDR_W   = 12;
  localparam int BUSY_BIT = 5;

  // register pages, selected by reg_addr[11:8]
  localparam logic [3:0] PG_D0      = 4'h4;
  localparam logic [3:0] PG_D1      = 4'h5;
  localparam logic [3:0] PG_D0_SELF = 4'h6;
  localparam logic [3:0] PG_D1_SELF = 4'h7;
  localparam logic [3:0] PG_STAT    = 4'h9;
  localparam logic [3:0] PG_STAT_SELF = 4'hB;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_D0,
    ACC_D1,
    ACC_STAT
  } acc_kind_e;
endpackage

// File: rtl/mbx_addr_dec.sv
module mbx_addr_dec
  import mbx_pkg::*;
#(
  parameter int NUM_CPU = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CPU_W-1:0]  req_id,
  output acc_kind_e         kind,
  output logic [CPU_W-1:0]  idx
);
  logic [3:0] page;
  logic       aligned;
  logic       self_ok;
  acc_kind_e  kind_raw;

  assign page    = addr[11:8];
  assign aligned = (addr[2:0] == 3'b000);
  assign self_ok = (addr[7:0] == 8'h00);

  always_comb begin
    kind_raw = ACC_NONE;
    idx      = addr[7:3];
    if (aligned) begin
      case (page)
        PG_D0:   kind_raw = ACC_D0;
        PG_D1:   kind_raw = ACC_D1;
        PG_STAT: kind_raw = ACC_STAT;
        PG_D0_SELF: if (self_ok) begin kind_raw = ACC_D0;   idx = req_id; end
        PG_D1_SELF: if (self_ok) begin kind_raw = ACC_D1;   idx = req_id; end
        PG_STAT_SELF: if (self_ok) begin kind_raw = ACC_STAT; idx = req_id; end
        default: kind_raw = ACC_NONE;
      endcase
    end
  end

  // slots beyond the configured count decode as unmapped
  assign kind = (int'(idx) < NUM_CPU) ? kind_raw : ACC_NONE;
endmodule

// File: rtl/mbx_slot.sv
module mbx_slot
  import mbx_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [SRC_W-1:0]  take_src,
  input  logic [DATA_W-1:0] take_d0,
  input  logic [DATA_W-1:0] take_d1,
  input  logic              sw_wr,
  input  logic              sw_busy,
  output logic              busy,
  output logic [SRC_W-1:0]  src,
  output logic [DATA_W-1:0] d0,
  output logic [DATA_W-1:0] d1
);
  logic busy_d;

  // an accepted message overrides a software write in the same cycle
  always_comb begin
    busy_d = busy;
    if (sw_wr) busy_d = sw_busy;
    if (take)  busy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy <= 1'b0;
    else        busy <= busy_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src <= '0;
      d0  <= '0;
      d1  <= '0;
    end else if (take) begin
      src <= take_src;
      d0  <= take_d0;
      d1  <= take_d1;
    end
  end
endmodule

// File: rtl/irq_mailbox.sv
module irq_mailbox
  import mbx_pkg::*;
#(
  parameter int NUM_CPU = 32,
  parameter int DATA_W  = 64,
  parameter int VEC_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_valid,
  input  logic [CPU_W-1:0]  msg_cpu,
  input  logic [SRC_W-1:0]  msg_src,
  input  logic [DATA_W-1:0] msg_d0,
  input  logic [DATA_W-1:0] msg_d1,
  input  logic [VEC_W-1:0]  ext_vec,
  output logic              msg_accept,
  output logic              msg_reject,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CPU_W-1:0]  reg_req_id,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              post_valid,
  output logic [CPU_W-1:0]  post_cpu,
  output logic [VEC_W-1:0]  post_vec
);
  localparam int STAT_PAD = DATA_W - SRC_W - 1;

  logic [NUM_CPU-1:0] busy_vec;
  logic [SRC_W-1:0]   src_arr [NUM_CPU];
  logic [DATA_W-1:0]  d0_arr  [NUM_CPU];
  logic [DATA_W-1:0]  d1_arr  [NUM_CPU];
  logic [NUM_CPU-1:0] slot_take;
  logic [NUM_CPU-1:0] slot_sw;

  acc_kind_e         acc_kind;
  logic [CPU_W-1:0]  acc_idx;
  logic              wr_stat;
  logic              cpu_ok;
  logic              tgt_busy;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_d;
  logic              unused_wbits;

  assign unused_wbits = ^{reg_wdata[DATA_W-1:BUSY_BIT+1], reg_wdata[BUSY_BIT-1:0]};

  // ---------------- message admission ----------------
  assign cpu_ok     = int'(msg_cpu) < NUM_CPU;
  assign tgt_busy   = cpu_ok ? busy_vec[msg_cpu] : 1'b1;
  assign msg_accept = msg_valid && !tgt_busy;
  assign msg_reject = msg_valid && tgt_busy;

  // ---------------- register decode ----------------
  mbx_addr_dec #(.NUM_CPU(NUM_CPU)) u_dec (
    .addr   (reg_addr),
    .req_id (reg_req_id),
    .kind   (acc_kind),
    .idx    (acc_idx)
  );

  assign wr_stat = reg_en && reg_we && (acc_kind == ACC_STAT);

  // ---------------- slot array ----------------
  for (genvar g = 0; g < NUM_CPU; g++) begin : g_slot
    assign slot_take[g] = msg_accept && (int'(msg_cpu) == g);
    assign slot_sw[g]   = wr_stat && (int'(acc_idx) == g);

    mbx_slot #(.DATA_W(DATA_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (slot_take[g]),
      .take_src (msg_src),
      .take_d0  (msg_d0),
      .take_d1  (msg_d1),
      .sw_wr    (slot_sw[g]),
      .sw_busy  (reg_wdata[BUSY_BIT]),
      .busy     (busy_vec[g]),
      .src      (src_arr[g]),
      .d0       (d0_arr[g]),
      .d1       (d1_arr[g])
    );
  end

  // ---------------- read path ----------------
  always_comb begin
    case (acc_kind)
      ACC_D0:   rd_mux = d0_arr[acc_idx];
      ACC_D1:   rd_mux = d1_arr[acc_idx];
      ACC_STAT: rd_mux = {{STAT_PAD{1'b0}}, busy_vec[acc_idx], src_arr[acc_idx]};
      default:  rd_mux = '0;
    endcase
  end

  always_comb begin
    rdata_d = reg_rdata;
    if (reg_en && !reg_we) rdata_d = rd_mux;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else        reg_rdata <= rdata_d;
  end

  // ---------------- interrupt post ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) post_valid <= 1'b0;
    else        post_valid <= msg_accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      post_cpu <= '0;
      post_vec <= '0;
    end else if (msg_accept) begin
      post_cpu <= msg_cpu;
      post_vec <= ext_vec;
    end
  end
endmodule

// File: rtl/irq_mailbox_chk.sv
module irq_mailbox_chk
  import mbx_pkg::*;
#(
  parameter int NUM_CPU = 32,
  parameter int VEC_W   = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               msg_valid,
  input logic [CPU_W-1:0]   msg_cpu,
  input logic [VEC_W-1:0]   ext_vec,
  input logic               msg_accept,
  input logic               msg_reject,
  input logic               post_valid,
  input logic [CPU_W-1:0]   post_cpu,
  input logic [VEC_W-1:0]   post_vec,
  input logic [NUM_CPU-1:0] busy_vec
);
  p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({msg_accept, msg_reject}));

  p_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_accept || msg_reject));

  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid |-> (!msg_accept && !msg_reject));

  p_reject_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_reject && int'(msg_cpu) < NUM_CPU) |-> busy_vec[msg_cpu]);

  p_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    msg_accept |=> busy_vec[$past(msg_cpu)]);

  p_post_r4: assert property (@(posedge clk) disable iff (!rst_n)
    msg_accept |=> (post_valid && post_cpu == $past(msg_cpu) && post_vec == $past(ext_vec)));

  p_nopost_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_accept |=> !post_valid);
endmodule

bind irq_mailbox irq_mailbox_chk #(.NUM_CPU(NUM_CPU), .VEC_W(VEC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .msg_valid  (msg_valid),
  .msg_cpu    (msg_cpu),
  .ext_vec    (ext_vec),
  .msg_accept (msg_accept),
  .msg_reject (msg_reject),
  .post_valid (post_valid),
  .post_cpu   (post_cpu),
  .post_vec   (post_vec),
  .busy_vec   (busy_vec)
);

// File: tb/sim_irq_mailbox.sv
module sim_irq_mailbox;
  localparam int NCPU = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        msg_valid;
  logic [4:0]  msg_cpu, msg_src, reg_req_id, post_cpu;
  logic [63:0] msg_d0, msg_d1, reg_wdata, reg_rdata;
  logic [5:0]  ext_vec, post_vec;
  logic        msg_accept, msg_reject, reg_en, reg_we, post_valid;
  logic [11:0] reg_addr;

  int errors = 0;
  int checks = 0;

  // behavioural model
  bit        m_busy [NCPU];
  bit [4:0]  m_src  [NCPU];
  bit [63:0] m_d0   [NCPU];
  bit [63:0] m_d1   [NCPU];

  always #5 clk = ~clk;

  irq_mailbox u0 (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_cpu(msg_cpu),
    .msg_src(msg_src), .msg_d0(msg_d0), .msg_d1(msg_d1), .ext_vec(ext_vec),
    .msg_accept(msg_accept), .msg_reject(msg_reject), .reg_en(reg_en),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_req_id(reg_req_id),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .post_valid(post_valid),
    .post_cpu(post_cpu), .post_vec(post_vec)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit [63:0] status_of(int n);
    return {58'd0, m_busy[n], m_src[n]};
  endfunction

  function automatic bit [63:0] model_read(int a, int rid);
    if (a % 8 != 0) return 64'd0;
    if (a >= 'h400 && a < 'h400 + 8*NCPU) return m_d0[(a - 'h400) / 8];
    if (a >= 'h500 && a < 'h500 + 8*NCPU) return m_d1[(a - 'h500) / 8];
    if (a >= 'h900 && a < 'h900 + 8*NCPU) return status_of((a - 'h900) / 8);
    if (a == 'h600) return m_d0[rid];
    if (a == 'h700) return m_d1[rid];
    if (a == 'hB00) return status_of(rid);
    return 64'd0;
  endfunction

  // one clock: drive, check the answer, advance model, check registered outputs
  task automatic step(string tag, bit v, int cpu, int src, bit [63:0] a0, bit [63:0] a1,
                      int vec, bit en, bit we, int addr, int rid, bit [63:0] wd);
    bit        exp_acc;
    bit [63:0] exp_rd;
    int        tgt;
    msg_valid = v; msg_cpu = 5'(cpu); msg_src = 5'(src); msg_d0 = a0; msg_d1 = a1;
    ext_vec = 6'(vec); reg_en = en; reg_we = we; reg_addr = 12'(addr);
    reg_req_id = 5'(rid); reg_wdata = wd;
    #1;
    exp_acc = v && !m_busy[cpu];
    chk({tag, " accept"}, {63'd0, msg_accept}, {63'd0, exp_acc});
    chk({tag, " reject"}, {63'd0, msg_reject}, {63'd0, v && !exp_acc});
    exp_rd = model_read(addr, rid);
    @(posedge clk);
    if (en && we) begin
      tgt = -1;
      if (addr % 8 == 0 && addr >= 'h900 && addr < 'h900 + 8*NCPU) tgt = (addr - 'h900) / 8;
      if (addr == 'hB00) tgt = rid;
      if (tgt >= 0) m_busy[tgt] = wd[5];
    end
    if (exp_acc) begin
      m_busy[cpu] = 1'b1; m_src[cpu] = 5'(src); m_d0[cpu] = a0; m_d1[cpu] = a1;
    end
    @(negedge clk);
    chk({tag, " R4 post_valid"}, {63'd0, post_valid}, {63'd0, exp_acc});
    if (exp_acc) begin
      chk({tag, " R4 post_cpu"}, {59'd0, post_cpu}, 64'(cpu));
      chk({tag, " R4 post_vec"}, {58'd0, post_vec}, 64'(vec));
    end
    if (en && !we) chk({tag, " rdata"}, reg_rdata, exp_rd);
  endtask

  task automatic rd(string tag, int addr, int rid);
    step(tag, 0, 0, 0, 0, 0, 0, 1, 0, addr, rid, 0);
  endtask

  task automatic wr(string tag, int addr, int rid, bit [63:0] wd);
    step(tag, 0, 0, 0, 0, 0, 0, 1, 1, addr, rid, wd);
  endtask

  task automatic msg(string tag, int cpu, int src, bit [63:0] a0, bit [63:0] a1, int vec);
    step(tag, 1, cpu, src, a0, a1, vec, 0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    #2000000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    int rpick [5];
    rpick = '{0, 1, 2, 3, 31};
    rst_n = 1'b0; msg_valid = 0; msg_cpu = 0; msg_src = 0; msg_d0 = 0; msg_d1 = 0;
    ext_vec = 0; reg_en = 0; reg_we = 0; reg_addr = 0; reg_req_id = 0; reg_wdata = 0;
    repeat (3) @(negedge clk);
    chk("R1 post_valid in reset", {63'd0, post_valid}, 64'd0);
    rst_n = 1'b1;

    // R1: everything reads zero
    rd("R1 stat0", 'h900, 0);
    rd("R1 stat31", 'h9F8, 0);
    rd("R1 d0_7", 'h438, 0);
    rd("R1 d1_7", 'h538, 0);
    rd("R1 self stat", 'hB00, 9);

    // R2 / R5 / R7
    msg("R2 take cpu3", 3, 'h15, 64'hA5A5_0000_1111_2222, 64'h0123_4567_89AB_CDEF, 'h2A);
    rd("R5 d0 cpu3", 'h418, 0);
    rd("R5 d1 cpu3", 'h518, 0);
    rd("R7 stat cpu3", 'h918, 0);

    // R3: locked slot turns away
    msg("R3 refuse cpu3", 3, 'h07, 64'hDEAD, 64'hBEEF, 'h11);
    rd("R3 d0 kept", 'h418, 0);
    rd("R3 stat kept", 'h918, 0);

    // R6 / R8 self-addressed
    rd("R6 self d0", 'h600, 3);
    rd("R6 self d1", 'h700, 3);
    rd("R8 self stat", 'hB00, 3);
    rd("R8 self stat other", 'hB00, 4);

    // R9 busy writes
    wr("R9 clear idx", 'h918, 0, 64'hFFFF_FFFF_FFFF_FFDF);
    rd("R9 stat after clear", 'h918, 0);
    rd("R9 data kept", 'h518, 0);
    wr("R9 set self", 'hB00, 3, 64'h20);
    rd("R9 stat after set", 'h918, 0);
    wr("R9 clear self", 'hB00, 3, 64'h0);
    rd("R9 stat after self clear", 'hB00, 3);

    // R10: clear and message collide on a busy slot
    msg("R10 prep", 3, 'h09, 64'h1, 64'h2, 'h05);
    step("R10 collide", 1, 3, 'h1E, 64'h77, 64'h88, 'h3F, 1, 1, 'h918, 0, 64'h0);
    rd("R10 stat", 'h918, 0);
    rd("R10 d0", 'h418, 0);

    // R11: write and message collide on a free slot
    step("R11 collide", 1, 3, 'h1E, 64'h77, 64'h88, 'h3F, 1, 1, 'hB00, 3, 64'h0);
    rd("R11 stat", 'h918, 0);
    rd("R11 d1", 'h518, 0);

    // boundary slots
    msg("R2 take cpu31", 31, 'h1F, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001, 'h3F);
    msg("R2 take cpu0", 0, 'h01, 64'h10, 64'h20, 'h00);
    rd("R5 d0 cpu31", 'h4F8, 0);
    rd("R5 d1 cpu0", 'h500, 0);
    rd("R7 stat cpu31", 'h9F8, 0);

    // R12 unmapped, misaligned, data writes
    rd("R12 off000", 'h000, 3);
    rd("R12 off608", 'h608, 3);
    rd("R12 off800", 'h800, 3);
    rd("R12 offA00", 'hA00, 3);
    rd("R12 offC00", 'hC00, 3);
    rd("R12 off41C", 'h41C, 3);
    wr("R12 write d0", 'h418, 0, 64'hCAFE);
    wr("R12 write d1 self", 'h700, 3, 64'hCAFE);
    rd("R12 d0 unchanged", 'h418, 0);
    rd("R12 d1 unchanged", 'h518, 0);

    // random collisions over a few slots
    for (int i = 0; i < 600; i++) begin
      int cpu, rid, sel, addr;
      bit v, en, we;
      cpu = rpick[$urandom_range(0, 4)];
      rid = rpick[$urandom_range(0, 4)];
      v   = ($urandom_range(0, 2) != 0);
      en  = ($urandom_range(0, 3) != 0);
      we  = ($urandom_range(0, 2) == 0);
      sel = $urandom_range(0, 6);
      case (sel)
        0: addr = 'h400 + 8*rid;
        1: addr = 'h500 + 8*cpu;
        2: addr = 'h600;
        3: addr = 'h700;
        4: addr = 'h900 + 8*cpu;
        5: addr = 'hB00;
        default: addr = 'h900 + 8*rid;
      endcase
      step("R10 R11 random", v, cpu, $urandom_range(0, 31),
           {$urandom, $urandom}, {$urandom, $urandom}, $urandom_range(0, 63),
           en, we, addr, rid, ($urandom_range(0, 1) != 0) ? 64'h20 : 64'h0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule